// File: doc/BRIEF.md
# Lane Mask Controller for Divergent Vector Execution

This block owns the active-lane mask of a 64-lane vector unit and updates it from scalar control-flow operations. A compare in the vector lanes produces one condition bit per lane; the scalar side then issues an operation to this block that folds the condition into the mask. Divergent regions are tracked without any internal stack. Each operation returns a saved-mask result, and the caller keeps it and hands it back on a later operation. Opening a conditional region parks the failing lanes in the returned word, the else-switch swaps the two lane groups, and closing the region ORs the parked lanes back in.

Loops collect exiting lanes in a break accumulator that the caller owns. The break operations build that accumulator. The loop operation removes the accumulated lanes from the mask and tells the caller whether any lane is still running. After a region open or an else-switch, a zero flag tells the caller that no lane is active, so the guarded code can be skipped.

Every operation finishes in one clock. The new mask, the saved-mask result and both flags are registered, and a response strobe rises in the cycle after the request.

Top module: `lane_mask_ctrl`

## Requirements
- R1: After a synchronous active-high reset, exec_mask is all ones and rsp_valid, rsp_saved, mask_zero and loop_again are all zero.
- R2: rsp_valid is high exactly in the cycle after a cycle with req_valid high. In a cycle without a request, exec_mask, mask_zero and loop_again keep their values.
- R3: Load (req_op 0): exec_mask becomes req_src and rsp_saved becomes the old mask.
- R4: Region open (req_op 1): exec_mask becomes old AND req_src, and rsp_saved becomes old XOR new, which is the set of lanes that were active and failed the condition.
- R5: Else-switch (req_op 2): rsp_saved becomes the old mask, and exec_mask becomes (old OR req_src) XOR old.
- R6: Region close (req_op 3): exec_mask becomes old OR req_src, and rsp_saved becomes the old mask.
- R7: Break (req_op 4): rsp_saved becomes exec_mask OR req_acc, and exec_mask does not change.
- R8: Conditional break (req_op 5) and else break (req_op 6): rsp_saved becomes req_src OR req_acc, and exec_mask does not change.
- R9: Loop end (req_op 7): exec_mask becomes old AND NOT req_src, rsp_saved becomes the old mask, and loop_again is set when the new mask is nonzero.
- R10: mask_zero is set to (new mask == 0) after a region open or an else-switch, and it is cleared by any other operation. loop_again is cleared by any operation other than loop end.
- R11: A correctly nested series of region open, else-switch and region close operations leaves every lane group with the mask that a stack-of-masks model predicts. After the outermost close, the mask equals the mask from before the outermost open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 3 | Operation code, values 0 to 7 as listed in R3 to R9 |
| req_src | input | LANES | Condition word or saved mask passed back by the caller |
| req_acc | input | LANES | Break accumulator operand |
| rsp_valid | output | 1 | Result strobe, one cycle after a request |
| rsp_saved | output | LANES | Saved-mask result of the last operation |
| exec_mask | output | LANES | Current active-lane mask |
| mask_zero | output | 1 | Mask became all zero after a region open or else-switch |
| loop_again | output | 1 | Mask is nonzero after a loop end |

## Verification
The hardest case to reach is a deeply nested divergence in which an inner region empties the mask completely. Recovery then depends only on the saved words that the caller passes back. The bench drives two-level nested open, else and close series with overlapping condition patterns, including an inner condition that disables every lane. At every step it compares the mask with a model that pushes and pops whole masks on an explicit stack, so the xor-based bookkeeping in the design is checked against a different formulation. Overlapping operands on the else-switch and on the loop end are also driven, because they are what separates the specified formulas from simpler ones that agree only on well-formed inputs.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [2:0] {
    OP_LOAD     = 3'd0,
    OP_OPEN     = 3'd1,
    OP_SWITCH   = 3'd2,
    OP_CLOSE    = 3'd3,
    OP_BRK      = 3'd4,
    OP_IF_BRK   = 3'd5,
    OP_ELSE_BRK = 3'd6,
    OP_LOOP     = 3'd7
  } lmc_op_e;
endpackage

// File: rtl/lmc_zero_detect.sv
// Grouped all-zero detector: ORs each group of GROUP bits, then NORs the groups.
module lmc_zero_detect #(
  parameter int LANES = 64,
  parameter int GROUP = 8
) (
  input  logic [LANES-1:0] vec,
  output logic             is_zero
);
  localparam int NGRP = (LANES + GROUP - 1) / GROUP;
  localparam int PADW = NGRP * GROUP;

  logic [PADW-1:0] padded;
  logic [NGRP-1:0] grp_any;

  always_comb begin
    padded = '0;
    padded[LANES-1:0] = vec;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |padded[g*GROUP +: GROUP];
  end

  assign is_zero = ~|grp_any;
endmodule

// File: rtl/lmc_mask_alu.sv
// Combinational next-state computation for one mask operation.
module lmc_mask_alu
  import lmc_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic [2:0]       op,
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] src,
  input  logic [LANES-1:0] acc,
  output logic [LANES-1:0] nxt_mask,
  output logic [LANES-1:0] nxt_saved,
  output logic             zero_op,
  output logic             loop_op
);
  logic [LANES-1:0] merged;

  always_comb begin
    merged    = cur_mask | src;
    nxt_mask  = cur_mask;
    nxt_saved = cur_mask;
    zero_op   = 1'b0;
    loop_op   = 1'b0;
    unique case (lmc_op_e'(op))
      OP_LOAD: nxt_mask = src;
      OP_OPEN: begin
        nxt_mask  = cur_mask & src;
        nxt_saved = cur_mask ^ (cur_mask & src);
        zero_op   = 1'b1;
      end
      OP_SWITCH: begin
        nxt_mask  = merged ^ cur_mask;
        zero_op   = 1'b1;
      end
      OP_CLOSE:               nxt_mask  = merged;
      OP_BRK:                 nxt_saved = cur_mask | acc;
      OP_IF_BRK, OP_ELSE_BRK: nxt_saved = src | acc;
      OP_LOOP: begin
        nxt_mask = cur_mask & ~src;
        loop_op  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lmc_state_reg.sv
// Registered state: mask, saved result, flags and response strobe.
module lmc_state_reg #(
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LANES-1:0] nxt_mask,
  input  logic [LANES-1:0] nxt_saved,
  input  logic             zero_op,
  input  logic             loop_op,
  input  logic             nxt_is_zero,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] saved_q,
  output logic             zero_q,
  output logic             loop_q,
  output logic             vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      saved_q <= '0;
      zero_q  <= 1'b0;
      loop_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= load;
      if (load) begin
        mask_q  <= nxt_mask;
        saved_q <= nxt_saved;
        zero_q  <= zero_op & nxt_is_zero;
        loop_q  <= loop_op & ~nxt_is_zero;
      end
    end
  end
endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl #(
  parameter int LANES = 64,
  parameter int ZGROUP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [LANES-1:0] req_src,
  input  logic [LANES-1:0] req_acc,
  output logic             rsp_valid,
  output logic [LANES-1:0] rsp_saved,
  output logic [LANES-1:0] exec_mask,
  output logic             mask_zero,
  output logic             loop_again
);
  logic [LANES-1:0] nxt_mask, nxt_saved;
  logic             zero_op, loop_op, nxt_is_zero;

  lmc_mask_alu #(.LANES(LANES)) u_alu (
    .op        (req_op),
    .cur_mask  (exec_mask),
    .src       (req_src),
    .acc       (req_acc),
    .nxt_mask  (nxt_mask),
    .nxt_saved (nxt_saved),
    .zero_op   (zero_op),
    .loop_op   (loop_op)
  );

  lmc_zero_detect #(.LANES(LANES), .GROUP(ZGROUP)) u_zdet (
    .vec     (nxt_mask),
    .is_zero (nxt_is_zero)
  );

  lmc_state_reg #(.LANES(LANES)) u_state (
    .clk         (clk),
    .rst         (rst),
    .load        (req_valid),
    .nxt_mask    (nxt_mask),
    .nxt_saved   (nxt_saved),
    .zero_op     (zero_op),
    .loop_op     (loop_op),
    .nxt_is_zero (nxt_is_zero),
    .mask_q      (exec_mask),
    .saved_q     (rsp_saved),
    .zero_q      (mask_zero),
    .loop_q      (loop_again),
    .vld_q       (rsp_valid)
  );
endmodule

// File: rtl/lane_mask_ctrl_checker.sv
module lane_mask_ctrl_checker #(
  parameter int LANES = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic [LANES-1:0] req_src,
  input logic [LANES-1:0] req_acc,
  input logic             rsp_valid,
  input logic [LANES-1:0] rsp_saved,
  input logic [LANES-1:0] exec_mask,
  input logic             mask_zero,
  input logic             loop_again
);
  assert_rsp_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(exec_mask) && $stable(mask_zero) && $stable(loop_again)));
  assert_open_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd1) |=>
      (exec_mask == ($past(exec_mask) & $past(req_src)) &&
       rsp_saved == ($past(exec_mask) ^ exec_mask)));
  assert_close_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd3) |=> exec_mask == ($past(exec_mask) | $past(req_src)));
  assert_brk_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd4) |=>
      ($stable(exec_mask) && rsp_saved == (exec_mask | $past(req_acc))));
  assert_loop_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd7) |=>
      (exec_mask == ($past(exec_mask) & ~$past(req_src)) && loop_again == (exec_mask != '0)));
  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == 3'd1 || req_op == 3'd2)) |=> mask_zero == (exec_mask == '0));
  assert_flags_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op != 3'd1 && req_op != 3'd2 && req_op != 3'd7) |=> (!mask_zero && !loop_again));
endmodule

bind lane_mask_ctrl lane_mask_ctrl_checker #(.LANES(LANES)) u_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .req_src(req_src), .req_acc(req_acc), .rsp_valid(rsp_valid),
  .rsp_saved(rsp_saved), .exec_mask(exec_mask), .mask_zero(mask_zero),
  .loop_again(loop_again)
);

// File: tb/lane_mask_ctrl_tb.sv
`timescale 1ns/1ps
module lane_mask_ctrl_tb;
  localparam int L = 64;
  typedef logic [L-1:0] m_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  m_t         req_src = '0, req_acc = '0;
  logic       rsp_valid, mask_zero, loop_again;
  m_t         rsp_saved, exec_mask;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  lane_mask_ctrl #(.LANES(L)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_src(req_src), .req_acc(req_acc), .rsp_valid(rsp_valid),
    .rsp_saved(rsp_saved), .exec_mask(exec_mask), .mask_zero(mask_zero),
    .loop_again(loop_again)
  );

  task automatic chk(input string req, input m_t act, input m_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge, sample results at the next falling edge.
  task automatic issue(input logic [2:0] op, input m_t src, input m_t acc);
    req_valid = 1'b1; req_op = op; req_src = src; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", m_t'(rsp_valid), m_t'(1));
  endtask

  task automatic t_reset;
    chk("R1 mask", exec_mask, '1);
    chk("R1 saved", rsp_saved, '0);
    chk("R1 flags", m_t'({rsp_valid, mask_zero, loop_again}), '0);
  endtask

  task automatic t_load_open;
    m_t old, c;
    old = 64'hF0F0_FFFF_0000_1234;
    issue(3'd0, old, '0);
    chk("R3 mask", exec_mask, old);
    chk("R3 saved", rsp_saved, '1);
    c = 64'h0FF0_F0F0_FFFF_1200;
    issue(3'd1, c, '0);
    chk("R4 mask", exec_mask, old & c);
    chk("R4 saved", rsp_saved, old & ~c);
    chk("R10 open nonzero", m_t'(mask_zero), '0);
    issue(3'd1, '0, '0);
    chk("R4 empty mask", exec_mask, '0);
    chk("R10 open zero", m_t'(mask_zero), m_t'(1));
  endtask

  task automatic t_idle;
    m_t held;
    held = exec_mask;
    repeat (3) @(negedge clk);
    chk("R2 idle valid", m_t'(rsp_valid), '0);
    chk("R2 idle mask", exec_mask, held);
    chk("R2 idle flag", m_t'(mask_zero), m_t'(1));
  endtask

  task automatic t_switch_close;
    issue(3'd0, 64'h0000_0000_0000_00FF, '0);
    issue(3'd2, 64'h0000_0000_0000_0FF0, '0);
    chk("R5 mask", exec_mask, 64'h0000_0000_0000_0F00);
    chk("R5 saved", rsp_saved, 64'h0000_0000_0000_00FF);
    chk("R10 switch nonzero", m_t'(mask_zero), '0);
    issue(3'd2, 64'h0000_0000_0000_0F00, '0);
    chk("R5 empty", exec_mask, '0);
    chk("R10 switch zero", m_t'(mask_zero), m_t'(1));
    issue(3'd3, 64'hAAAA_0000_0000_0001, '0);
    chk("R6 mask", exec_mask, 64'hAAAA_0000_0000_0001);
    chk("R6 saved", rsp_saved, '0);
    chk("R10 close clears", m_t'(mask_zero), '0);
  endtask

  task automatic t_breaks;
    m_t m;
    m = 64'h1234_5678_9ABC_DEF0;
    issue(3'd0, m, '0);
    issue(3'd4, 64'hFFFF, 64'h8000_0000_0000_0001);
    chk("R7 saved", rsp_saved, m | 64'h8000_0000_0000_0001);
    chk("R7 mask held", exec_mask, m);
    issue(3'd5, 64'h00F0, 64'h0F00);
    chk("R8 if-break saved", rsp_saved, 64'h0FF0);
    chk("R8 if-break mask held", exec_mask, m);
    issue(3'd6, 64'hF000_0000_0000_0000, 64'h1);
    chk("R8 else-break saved", rsp_saved, 64'hF000_0000_0000_0001);
    chk("R8 else-break mask held", exec_mask, m);
  endtask

  task automatic t_loop;
    issue(3'd0, 64'hF0F0_F0F0_F0F0_F0F0, '0);
    issue(3'd7, 64'hFF00_0000_0000_000F, '0);
    chk("R9 mask", exec_mask, 64'h00F0_F0F0_F0F0_F0F0);
    chk("R9 saved", rsp_saved, 64'hF0F0_F0F0_F0F0_F0F0);
    chk("R9 again", m_t'(loop_again), m_t'(1));
    issue(3'd4, '0, '0);
    chk("R10 loop flag cleared", m_t'(loop_again), '0);
    issue(3'd7, '1, '0);
    chk("R9 exit mask", exec_mask, '0);
    chk("R9 exit flag", m_t'(loop_again), '0);
  endtask

  // Nested region series checked against an explicit stack of masks.
  task automatic t_nested(input m_t start, input m_t c1, input m_t c2);
    m_t stk [0:3];
    m_t s1, s2;
    int sp = 0;
    issue(3'd0, start, '0);
    stk[sp] = start; sp++;
    issue(3'd1, c1, '0); s1 = rsp_saved;
    chk("R11 outer then", exec_mask, start & c1);
    stk[sp] = start & c1; sp++;
    issue(3'd1, c2, '0); s2 = rsp_saved;
    chk("R11 inner then", exec_mask, stk[sp-1] & c2);
    chk("R10 inner zero flag", m_t'(mask_zero), m_t'((stk[sp-1] & c2) == '0));
    issue(3'd2, s2, '0); s2 = rsp_saved;
    chk("R11 inner else", exec_mask, stk[sp-1] & ~c2);
    issue(3'd3, s2, '0);
    sp--;
    chk("R11 inner close", exec_mask, stk[sp]);
    issue(3'd2, s1, '0); s1 = rsp_saved;
    chk("R11 outer else", exec_mask, stk[0] & ~c1);
    issue(3'd3, s1, '0);
    sp--;
    chk("R11 outer close", exec_mask, stk[sp]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_open();
    t_idle();
    t_switch_close();
    t_breaks();
    t_loop();
    t_nested(64'hFFFF_0000_FFFF_0F0F, 64'hFF00_FF00_FF00_FF00, 64'hF0F0_F0F0_F0F0_F0F0);
    t_nested('1, 64'h0000_FFFF_0000_FFFF, 64'h0);
    t_nested(64'h8421_8421_8421_8421, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule